// File: doc/BRIEF.md
# Card Status Change Interrupt Controller

This block collects status-change events from up to `NSOCK` card sockets and turns them into interrupts. Each socket supplies six live signals: card present, ready, two active-low battery-voltage pins (the first doubling as the status-change pin of an I/O card), write-protect and power-good. The signals are synchronised. Every transition of an event source, rising or falling, sets a sticky bit in that socket's change register.

A per-socket enable register, laid out like the change register, selects which pending changes may interrupt. A global routing register steers each event class either to the PCI-style interrupt output or to the legacy interrupt output. The two outputs are ORed over all sockets. A per-socket control register selects I/O-card or memory-card event semantics and drives an inverted card-reset output. Software reaches the registers through a simple select/address/read/write port. A read of the change register returns the pending bits and clears them, so one dummy read discards stale events, including those that settling inputs leave after reset.

Top module: `card_evt_ctrl`

## Requirements
- R1: After reset the control, enable, change and routing registers read 0, both interrupt outputs are low and every `card_rst` bit is 1.
- R2: Any transition, in either direction, of a synchronised event source sets its change bit, and the bit stays set until the change register is read. The change bits are: bit 0 = first battery pin / status change, bit 1 = second battery pin, bit 2 = ready, bit 3 = card present.
- R3: A read of the change register (address 2) returns the pending bits and clears them in the same access, so a single read discards stale events.
- R4: An event whose edge is captured in the same cycle as a clearing read is not lost; it is pending after that read.
- R5: With control bit 0 set (I/O-card mode), transitions of ready and of the second battery pin are not captured, while change bits 0 and 3 are still captured. With bit 0 clear (memory-card mode) all four sources are captured.
- R6: Enable register (address 3, same bit layout as the change register): a pending change raises an interrupt only if its enable bit is set. With nothing both pending and enabled, both outputs are low.
- R7: Routing register (address 4, shared by all sockets), bit e: 1 sends event class e to `irq_pci`, 0 sends it to `irq_leg`.
- R8: Each interrupt output is the OR over all sockets of (change AND enable AND its routing selection). It stays asserted until the pending bits are read.
- R9: Status register (address 0) reports the live synchronised pins: bit 0 first battery pin level, bit 1 second battery pin level (both active-low, 0 reports the condition), bit 2 present, bit 3 write-protect, bit 4 ready, bit 5 power-good, bits 7:6 zero.
- R10: Control bit 1 (address 1) is an inverted reset: while it is 0, that socket's `card_rst` is 1. Writing 1 releases the reset.
- R11: Registers and events of one socket have no effect on any other socket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | SW | Socket selected by the access |
| bus_addr | input | 3 | Register address within the socket |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered on the read cycle |
| pin_present | input | NSOCK | Card present, per socket |
| pin_ready | input | NSOCK | Card ready, per socket |
| pin_bvd1_n | input | NSOCK | First battery pin / status change, active-low |
| pin_bvd2_n | input | NSOCK | Second battery pin, active-low |
| pin_wp | input | NSOCK | Write-protect, per socket |
| pin_pwr | input | NSOCK | Power-good, per socket |
| card_rst | output | NSOCK | Card reset, active-high |
| irq_pci | output | 1 | Interrupt for routed-high events |
| irq_leg | output | 1 | Interrupt for routed-low events |

## Verification
The bench aims at the collision between a clearing read and a new edge. A design that clears unconditionally on a read loses the event, and the next read comes back empty. It toggles the ready and second battery pins in I/O-card mode, where a design that ignores the mode would report them. It also drives falling edges, which a rising-only detector would miss. The routing flip and the OR across two sockets expose an inverted routing polarity or a socket left out of the OR as an interrupt on the wrong output, or as none at all.

// File: rtl/cevt_pkg.sv
package cevt_pkg;

   localparam int NEVT = 4;
   localparam int DW   = 8;
   localparam int AW   = 3;
   localparam int PINW = 6;
   localparam int CTW  = 2;

   localparam logic [AW-1:0] A_STAT  = 3'd0;
   localparam logic [AW-1:0] A_CTRL  = 3'd1;
   localparam logic [AW-1:0] A_CHG   = 3'd2;
   localparam logic [AW-1:0] A_ENA   = 3'd3;
   localparam logic [AW-1:0] A_ROUTE = 3'd4;

   // event bit positions (shared by change, enable and routing registers)
   localparam int E_BV1 = 0;
   localparam int E_BV2 = 1;
   localparam int E_RDY = 2;
   localparam int E_DET = 3;

   // events still captured in I/O-card mode
   localparam logic [NEVT-1:0] IO_KEEP = (NEVT'(1) << E_BV1) | (NEVT'(1) << E_DET);

   typedef struct packed {
      logic pwr;
      logic wp;
      logic rdy;
      logic present;
      logic bvd2_n;
      logic bvd1_n;
   } pins_t;

   function automatic logic [NEVT-1:0] evt_src(pins_t p);
      logic [NEVT-1:0] v;
      v        = '0;
      v[E_BV1] = p.bvd1_n;
      v[E_BV2] = p.bvd2_n;
      v[E_RDY] = p.rdy;
      v[E_DET] = p.present;
      return v;
   endfunction

   function automatic logic [DW-1:0] stat_byte(pins_t p);
      return {2'b00, p.pwr, p.rdy, p.wp, p.present, p.bvd2_n, p.bvd1_n};
   endfunction

endpackage

// File: rtl/cevt_sync.sv
module cevt_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cevt_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/cevt_sock.sv
module cevt_sock
   import cevt_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  pins_t           pins,
   input  logic            wr_ctrl,
   input  logic            wr_ena,
   input  logic            rd_chg,
   input  logic [DW-1:0]   wdata,
   output logic [CTW-1:0]  ctrl_q,
   output logic [NEVT-1:0] ena_q,
   output logic [NEVT-1:0] chg_q,
   output logic [NEVT-1:0] pend,
   output logic            card_rst
);

   logic [NEVT-1:0] src, prev_q, chg_edge, keep_m, new_evt;
   logic            io_mode;

   assign io_mode  = ctrl_q[0];
   assign src      = evt_src(pins);
   assign chg_edge = src ^ prev_q;
   assign keep_m   = io_mode ? IO_KEEP : '1;
   assign new_evt  = chg_edge & keep_m;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         chg_q  <= '0;
      end else begin
         prev_q <= src;
         if (rd_chg) chg_q <= new_evt;
         else        chg_q <= chg_q | new_evt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ena_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[CTW-1:0];
         if (wr_ena)  ena_q  <= wdata[NEVT-1:0];
      end
   end

   assign pend     = chg_q & ena_q;
   assign card_rst = ~ctrl_q[1];

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_chg |=> ((chg_q & $past(chg_q)) == $past(chg_q)));          // R2
   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_chg && new_evt == '0) |=> (chg_q == '0));                    // R3
   AST_KEEP_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_chg |=> ((chg_q & $past(new_evt)) == $past(new_evt)));       // R4
   AST_IO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (io_mode && !rd_chg) |=> $stable(chg_q[E_RDY:E_BV2]));            // R5

endmodule

// File: rtl/cevt_irq.sv
module cevt_irq
   import cevt_pkg::*;
#(
   parameter int NSOCK   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSOCK*NEVT-1:0] pend,
   input  logic [NEVT-1:0]       route,
   output logic                  irq_pci,
   output logic                  irq_leg
);

   logic any_pci, any_leg;

   always_comb begin
      any_pci = 1'b0;
      any_leg = 1'b0;
      for (int s = 0; s < NSOCK; s++) begin
         any_pci = any_pci | (|(pend[s*NEVT +: NEVT] &  route));
         any_leg = any_leg | (|(pend[s*NEVT +: NEVT] & ~route));
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_pci <= 1'b0;
            irq_leg <= 1'b0;
         end else begin
            irq_pci <= any_pci;
            irq_leg <= any_leg;
         end
      end

      AST_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
         (|pend) |=> (irq_pci || irq_leg));                            // R7
      AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (pend == '0) |=> (!irq_pci && !irq_leg));                     // R6
   end else begin : g_comb
      assign irq_pci = any_pci;
      assign irq_leg = any_leg;

      AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (pend == '0) |-> (!irq_pci && !irq_leg));                     // R6
   end

endmodule

// File: rtl/card_evt_ctrl.sv
module card_evt_ctrl
   import cevt_pkg::*;
#(
   parameter int NSOCK       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b1,
   localparam int SW = (NSOCK > 1) ? $clog2(NSOCK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SW-1:0]    bus_sel,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [NSOCK-1:0] pin_present,
   input  logic [NSOCK-1:0] pin_ready,
   input  logic [NSOCK-1:0] pin_bvd1_n,
   input  logic [NSOCK-1:0] pin_bvd2_n,
   input  logic [NSOCK-1:0] pin_wp,
   input  logic [NSOCK-1:0] pin_pwr,
   output logic [NSOCK-1:0] card_rst,
   output logic             irq_pci,
   output logic             irq_leg
);

   if (NSOCK < 1 || NSOCK > 8) begin : g_bad_nsock
      $error("card_evt_ctrl: NSOCK must be 1..8");
   end

   localparam int VW = NSOCK * PINW;

   logic [VW-1:0]         raw_v, sync_v;
   pins_t                 sync_p [NSOCK];
   logic [CTW-1:0]        ctrl_q [NSOCK];
   logic [NEVT-1:0]       ena_q  [NSOCK];
   logic [NEVT-1:0]       chg_q  [NSOCK];
   logic [NSOCK*NEVT-1:0] pend_v;
   logic [NSOCK-1:0]      hit;
   logic [NEVT-1:0]       route_q;
   logic [DW-1:0]         rd_mux;
   logic                  unused_wdata;

   assign unused_wdata = ^bus_wdata[DW-1:NEVT];

   for (genvar s = 0; s < NSOCK; s++) begin : g_pins
      pins_t rp;
      assign rp.pwr     = pin_pwr[s];
      assign rp.wp      = pin_wp[s];
      assign rp.rdy     = pin_ready[s];
      assign rp.present = pin_present[s];
      assign rp.bvd2_n  = pin_bvd2_n[s];
      assign rp.bvd1_n  = pin_bvd1_n[s];
      assign raw_v[s*PINW +: PINW] = rp;
   end

   cevt_sync #(.W(VW), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_v),
      .q    (sync_v)
   );

   for (genvar s = 0; s < NSOCK; s++) begin : g_sock
      logic wr_c, wr_e, rd_c;
      assign hit[s]    = (bus_sel == SW'(s));
      assign wr_c      = bus_wr & hit[s] & (bus_addr == A_CTRL);
      assign wr_e      = bus_wr & hit[s] & (bus_addr == A_ENA);
      assign rd_c      = bus_rd & hit[s] & (bus_addr == A_CHG);
      assign sync_p[s] = pins_t'(sync_v[s*PINW +: PINW]);

      cevt_sock i_sock (
         .clk     (clk),
         .rst_n   (rst_n),
         .pins    (sync_p[s]),
         .wr_ctrl (wr_c),
         .wr_ena  (wr_e),
         .rd_chg  (rd_c),
         .wdata   (bus_wdata),
         .ctrl_q  (ctrl_q[s]),
         .ena_q   (ena_q[s]),
         .chg_q   (chg_q[s]),
         .pend    (pend_v[s*NEVT +: NEVT]),
         .card_rst(card_rst[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              route_q <= '0;
      else if (bus_wr && bus_addr == A_ROUTE)  route_q <= bus_wdata[NEVT-1:0];
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr == A_ROUTE) begin
         rd_mux[NEVT-1:0] = route_q;
      end else begin
         for (int s = 0; s < NSOCK; s++) begin
            if (hit[s]) begin
               case (bus_addr)
                  A_STAT:  rd_mux            = stat_byte(sync_p[s]);
                  A_CTRL:  rd_mux[CTW-1:0]   = ctrl_q[s];
                  A_CHG:   rd_mux[NEVT-1:0]  = chg_q[s];
                  A_ENA:   rd_mux[NEVT-1:0]  = ena_q[s];
                  default: rd_mux            = '0;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   cevt_irq #(.NSOCK(NSOCK), .OUT_REG(IRQ_REG)) i_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend   (pend_v),
      .route  (route_q),
      .irq_pci(irq_pci),
      .irq_leg(irq_leg)
   );

   AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL && hit[0] && bus_wdata[1]) |=> !card_rst[0]); // R10

endmodule

// File: tb/test_card_evt_ctrl.sv
module test_card_evt_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bus_sel = '0;
   logic [2:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic [NS-1:0] p_present = '0, p_rdy = '0, p_bvd1_n = '1, p_bvd2_n = '1;
   logic [NS-1:0] p_wp = '0, p_pwr = '0;
   logic [NS-1:0] card_rst;
   logic          irq_pci, irq_leg;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   card_evt_ctrl i_card_evt_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_present(p_present), .pin_ready(p_rdy), .pin_bvd1_n(p_bvd1_n),
      .pin_bvd2_n(p_bvd2_n), .pin_wp(p_wp), .pin_pwr(p_pwr),
      .card_rst(card_rst), .irq_pci(irq_pci), .irq_leg(irq_leg)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: got=0x%0h exp=0x%0h", req, what, got, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int sel, input int addr, input int data);
      @(negedge clk);
      bus_sel = 2'(sel); bus_addr = 3'(addr); bus_wdata = 8'(data); bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int sel, input int addr, output int data);
      @(negedge clk);
      bus_sel = 2'(sel); bus_addr = 3'(addr); bus_rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      data = int'(bus_rdata);
   endtask

   task automatic flush_all();
      int d;
      for (int s = 0; s < NS; s++) rd(s, 2, d);
   endtask

   task automatic t_reset();
      int d;
      step(5);
      chk("R1", "irq_pci", int'(irq_pci), 0);
      chk("R1", "irq_leg", int'(irq_leg), 0);
      chk("R1", "card_rst", int'(card_rst), 'hF);
      rd(0, 1, d); chk("R1", "ctrl s0", d, 0);
      rd(2, 3, d); chk("R1", "ena s2", d, 0);
      rd(1, 4, d); chk("R1", "route", d, 0);
      flush_all();
      rd(0, 2, d); chk("R3", "chg after dummy read", d, 0);
   endtask

   task automatic t_status();
      int d;
      p_present[1] = 1'b1; p_wp[1] = 1'b1; p_bvd2_n[1] = 1'b0; p_pwr[1] = 1'b1;
      step(4);
      rd(1, 0, d); chk("R9", "stat s1", d, 'h2D);
      rd(0, 0, d); chk("R11", "stat s0 untouched", d, 'h03);
      rd(1, 2, d); chk("R2", "chg s1 present+bvd2", d, 'h0A);
   endtask

   task automatic t_edges();
      int d;
      p_rdy[0] = 1'b1; step(5);
      rd(0, 2, d); chk("R2", "rise ready", d, 'h04);
      rd(0, 2, d); chk("R3", "cleared by read", d, 'h00);
      p_rdy[0] = 1'b0; p_bvd1_n[0] = 1'b0; step(5);
      rd(0, 2, d); chk("R2", "falling edges", d, 'h05);
      rd(3, 2, d); chk("R11", "chg s3 untouched", d, 'h00);
      p_bvd1_n[0] = 1'b1; step(5);
      rd(0, 2, d); chk("R2", "bvd1 rise", d, 'h01);
   endtask

   task automatic t_iomode();
      int d;
      wr(1, 1, 'h01);
      rd(1, 1, d); chk("R5", "ctrl readback", d, 'h01);
      p_rdy[1] = ~p_rdy[1]; p_bvd2_n[1] = ~p_bvd2_n[1]; step(5);
      rd(1, 2, d); chk("R5", "io mode ignores ready/bvd2", d, 'h00);
      p_bvd1_n[1] = 1'b0; step(5);
      rd(1, 2, d); chk("R5", "io mode status change", d, 'h01);
      p_bvd1_n[1] = 1'b1; step(5);
      rd(1, 2, d);
      wr(1, 1, 'h00);
   endtask

   task automatic t_irq();
      int d;
      p_present[2] = 1'b1; step(5);
      chk("R6", "no irq when disabled", int'(irq_pci) | int'(irq_leg), 0);
      wr(2, 3, 'h08); step(3);
      chk("R7", "legacy route leg", int'(irq_leg), 1);
      chk("R7", "legacy route pci", int'(irq_pci), 0);
      wr(0, 4, 'h08); step(3);
      chk("R7", "pci route pci", int'(irq_pci), 1);
      chk("R7", "pci route leg", int'(irq_leg), 0);
      rd(2, 2, d); chk("R3", "chg s2", d, 'h08);
      step(3);
      chk("R8", "irq drops after read", int'(irq_pci) | int'(irq_leg), 0);
      wr(2, 3, 'h00);
   endtask

   task automatic t_or();
      int d;
      wr(0, 3, 'h04); wr(3, 3, 'h04); wr(0, 4, 'h04);
      p_rdy[3] = 1'b1; step(5);
      chg_irq("R8", "socket 3", 1);
      rd(3, 2, d); step(3);
      chg_irq("R8", "socket 3 cleared", 0);
      p_rdy[0] = 1'b1; step(5);
      chg_irq("R8", "socket 0", 1);
      rd(0, 2, d); step(3);
      chg_irq("R8", "socket 0 cleared", 0);
   endtask

   task automatic chg_irq(input string req, input string what, input int exp);
      chk(req, what, int'(irq_pci), exp);
   endtask

   task automatic t_collide();
      int d;
      p_rdy[0] = 1'b0; step(5);
      @(negedge clk); p_present[0] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); bus_sel = 2'd0; bus_addr = 3'd2; bus_rd = 1'b1;
      @(posedge clk);
      @(negedge clk); bus_rd = 1'b0;
      chk("R4", "read before collision", int'(bus_rdata), 'h04);
      rd(0, 2, d); chk("R4", "event kept across read", d, 'h08);
   endtask

   task automatic t_card_rst();
      int d;
      wr(0, 1, 'h02); step(1);
      chk("R10", "release s0", int'(card_rst), 'hE);
      wr(0, 1, 'h03); step(1);
      rd(0, 1, d); chk("R10", "ctrl s0", d, 'h03);
      chk("R10", "still released", int'(card_rst), 'hE);
      wr(0, 1, 'h00); step(1);
      chk("R10", "held again", int'(card_rst), 'hF);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got=expired exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_status();
      t_edges();
      t_iomode();
      t_irq();
      t_or();
      t_collide();
      t_card_rst();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule